// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer with Register Window

This block is a system watchdog. A 10-bit down-counter steps once for every pulse on an external periodic tick input; in a typical system the ticks are about 0.6 s apart. Software reaches the block through a small 16-bit register window. Each register sits at a byte offset, and byte enables select which lanes a write touches. Software arms the watchdog by clearing a halt bit. It then has to write to the reload register before the counter runs down.

When the counter runs out, the block records a first-timeout status and reloads itself from the initial-value register. If the counter runs out again before software has cleared that status, the block records a second timeout. Unless a reset-inhibit flag is set, it then drives a one-clock system reset pulse. A strap input can lock the inhibit flag so that software cannot clear it. This keeps a board that is being brought up from resetting itself.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the register at offset 0x08 reads 0x0801 (halt at bit 11 set, reset-inhibit at bit 0 set), the register at 0x12 reads 0x0004, and the registers at 0x00, 0x04 and 0x06 read 0x0000.
- R2: While the halt bit (0x08 bit 11) is 0, each tick lowers the count by one. While it is 1, ticks leave the count unchanged. The bit reads back as written.
- R3: A write of any value, with any nonzero byte enable, to offset 0x00 loads the counter from bits [9:0] of 0x12. Reading 0x00 returns the live count in bits [9:0] and zeros above. Such a write leaves the status registers unchanged.
- R4: At offset 0x12, bits [9:0] hold the initial value and bits [15:10] are plain storage. A write whose resulting bits [9:0] would be below 4 leaves those ten bits unchanged, but still stores bits [15:10].
- R5: Byte enable bit 0 gates data bits [7:0] and byte enable bit 1 gates data bits [15:8]. Lanes that are not enabled keep their stored value.
- R6: A tick that arrives while the count is 1 or 0 and halt is 0 is an expiry. The counter reloads from the initial value and sets the first-timeout flag, 0x04 bit 3.
- R7: An expiry while 0x04 bit 3 is already set also sets the second-timeout flag, 0x06 bit 1. If reset-inhibit is 0, it additionally sets 0x06 bit 0 (reset issued) and pulses the reset output.
- R8: Writing 1 to 0x04 bit 3, or to 0x06 bits [1:0], clears those bits. Writing 0 leaves them unchanged.
- R9: While the lock strap is 1, the reset-inhibit bit (0x08 bit 0) reads 1 and a write of 0 to it has no effect. While the lock strap is 0, the bit reads back as written.
- R10: The reset output is high for exactly one clock per second timeout, and it never goes high while reset-inhibit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock periodic count strobe |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 5 | Byte offset of the register |
| bus_be | input | 2 | Byte lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| reboot_lock_i | input | 1 | Strap that holds reset-inhibit at 1 |
| sys_rst_o | output | 1 | One-clock system reset pulse |

## Verification
The bench writes initial values of 2 and 3. A design that forgot the floor would accept them, and one that rejected the whole word would lose the upper storage bits. It runs the counter down to 1, then ticks once more to reach an expiry. An off-by-one design would show the expiry a tick early or late, or would hold the counter at 0. It makes partial-lane writes and reload writes with status pending. A wrong design would move the halt bit, or would wipe the first-timeout flag on reload. It drives a second timeout with reset-inhibit clear, set, and locked by the strap. A design with a leaky gate would emit a reset pulse, and one with a wide pulse would be counted twice.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Register window byte offsets
  localparam logic [7:0] OFS_RELOAD = 8'h00;
  localparam logic [7:0] OFS_STAT1  = 8'h04;
  localparam logic [7:0] OFS_STAT2  = 8'h06;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_INIT   = 8'h12;

  // Bit positions inside the registers
  localparam int HALT_BIT      = 11;
  localparam int INHIBIT_BIT   = 0;
  localparam int FIRST_TO_BIT  = 3;
  localparam int SECOND_TO_BIT = 1;
  localparam int ISSUED_BIT    = 0;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_RELOAD,
    RSEL_STAT1,
    RSEL_STAT2,
    RSEL_CTRL,
    RSEL_INIT
  } reg_sel_e;

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_decode.sv
module wdt_decode
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_STAT1  = ADDR_W'(OFS_STAT1);
  localparam logic [ADDR_W-1:0] A_STAT2  = ADDR_W'(OFS_STAT2);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_INIT   = ADDR_W'(OFS_INIT);

  always_comb begin
    sel = RSEL_NONE;
    unique case (addr)
      A_RELOAD: sel = RSEL_RELOAD;
      A_STAT1:  sel = RSEL_STAT1;
      A_STAT2:  sel = RSEL_STAT2;
      A_CTRL:   sel = RSEL_CTRL;
      A_INIT:   sel = RSEL_INIT;
      default:  sel = RSEL_NONE;
    endcase
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 10,
  parameter int INIT_MIN = 4,
  parameter int INIT_RST = 4,
  localparam int LANES   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_init,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  input  logic              lock,
  output logic              halt,
  output logic              inhibit,
  output logic [DATA_W-1:0] init_word
);
  localparam int HALT_LANE    = HALT_BIT / 8;
  localparam int INHIBIT_LANE = INHIBIT_BIT / 8;

  logic              halt_q, halt_d;
  logic              inhibit_q, inhibit_d;
  logic [DATA_W-1:0] init_q, init_d, init_mrg;

  // Per-lane merge of write data with the stored initial-value word
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign init_mrg[l*8 +: 8] = be[l] ? wdata[l*8 +: 8] : init_q[l*8 +: 8];
  end

  always_comb begin
    halt_d = halt_q;
    if (wr_ctrl && be[HALT_LANE]) halt_d = wdata[HALT_BIT];
  end

  always_comb begin
    inhibit_d = inhibit_q;
    if (wr_ctrl && be[INHIBIT_LANE]) inhibit_d = wdata[INHIBIT_BIT];
    if (lock) inhibit_d = 1'b1;
  end

  always_comb begin
    init_d = init_q;
    if (wr_init) begin
      init_d[DATA_W-1:CNT_W] = init_mrg[DATA_W-1:CNT_W];
      if (init_mrg[CNT_W-1:0] >= CNT_W'(INIT_MIN))
        init_d[CNT_W-1:0] = init_mrg[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q    <= 1'b1;
      inhibit_q <= 1'b1;
      init_q    <= DATA_W'(INIT_RST);
    end else begin
      halt_q    <= halt_d;
      inhibit_q <= inhibit_d;
      init_q    <= init_d;
    end
  end

  assign halt      = halt_q;
  assign inhibit   = inhibit_q;
  assign init_word = init_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step_en;

  assign step_en = tick && !halt && !reload;
  assign expire  = step_en && (cnt_q <= CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (reload)       cnt_d = init_val;
    else if (expire)  cnt_d = init_val;
    else if (step_en) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic inhibit,
  input  logic clr_first,
  input  logic clr_second,
  input  logic clr_issued,
  output logic first_to,
  output logic second_to,
  output logic issued,
  output logic sys_rst
);
  logic first_q, first_d;
  logic second_q, second_d;
  logic issued_q, issued_d;
  logic rst_q, rst_d;
  logic second_hit;

  assign second_hit = expire && first_q;

  // An event that sets a flag wins over a clear in the same cycle
  always_comb begin
    first_d  = first_q;
    second_d = second_q;
    issued_d = issued_q;
    if (clr_first)  first_d  = 1'b0;
    if (clr_second) second_d = 1'b0;
    if (clr_issued) issued_d = 1'b0;
    if (expire)     first_d  = 1'b1;
    if (second_hit) second_d = 1'b1;
    if (second_hit && !inhibit) issued_d = 1'b1;
    rst_d = second_hit && !inhibit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= 1'b0;
      second_q <= 1'b0;
      issued_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      first_q  <= first_d;
      second_q <= second_d;
      issued_q <= issued_d;
      rst_q    <= rst_d;
    end
  end

  assign first_to  = first_q;
  assign second_to = second_q;
  assign issued    = issued_q;
  assign sys_rst   = rst_q;
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 10,
  parameter int INIT_MIN = 4,
  parameter int INIT_RST = 4,
  localparam int LANES   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              reboot_lock_i,
  output logic              sys_rst_o
);
  logic              rst_sync_n;
  reg_sel_e          sel;
  logic              wr_any;
  logic              reload_stb, wr_ctrl, wr_init, wr_st1, wr_st2;
  logic              halt_w, inhibit_w;
  logic [DATA_W-1:0] init_word_w;
  logic [CNT_W-1:0]  init_field_w, count_w;
  logic              expire_w;
  logic              first_w, second_w, issued_w;
  logic              clr_first, clr_second, clr_issued;

  wdt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  wdt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr(bus_addr),
    .sel (sel)
  );

  assign wr_any     = bus_wr && (|bus_be);
  assign reload_stb = wr_any && (sel == RSEL_RELOAD);
  assign wr_ctrl    = wr_any && (sel == RSEL_CTRL);
  assign wr_init    = wr_any && (sel == RSEL_INIT);
  assign wr_st1     = wr_any && (sel == RSEL_STAT1);
  assign wr_st2     = wr_any && (sel == RSEL_STAT2);

  assign clr_first  = wr_st1 && bus_be[FIRST_TO_BIT/8]  && bus_wdata[FIRST_TO_BIT];
  assign clr_second = wr_st2 && bus_be[SECOND_TO_BIT/8] && bus_wdata[SECOND_TO_BIT];
  assign clr_issued = wr_st2 && bus_be[ISSUED_BIT/8]    && bus_wdata[ISSUED_BIT];

  wdt_regs #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .INIT_MIN(INIT_MIN),
    .INIT_RST(INIT_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_ctrl  (wr_ctrl),
    .wr_init  (wr_init),
    .wdata    (bus_wdata),
    .be       (bus_be),
    .lock     (reboot_lock_i),
    .halt     (halt_w),
    .inhibit  (inhibit_w),
    .init_word(init_word_w)
  );

  assign init_field_w = init_word_w[CNT_W-1:0];

  wdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick_i),
    .halt    (halt_w),
    .reload  (reload_stb),
    .init_val(init_field_w),
    .count   (count_w),
    .expire  (expire_w)
  );

  wdt_status u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .expire    (expire_w),
    .inhibit   (inhibit_w),
    .clr_first (clr_first),
    .clr_second(clr_second),
    .clr_issued(clr_issued),
    .first_to  (first_w),
    .second_to (second_w),
    .issued    (issued_w),
    .sys_rst   (sys_rst_o)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      RSEL_RELOAD: bus_rdata[CNT_W-1:0] = count_w;
      RSEL_STAT1:  bus_rdata[FIRST_TO_BIT] = first_w;
      RSEL_STAT2: begin
        bus_rdata[SECOND_TO_BIT] = second_w;
        bus_rdata[ISSUED_BIT]    = issued_w;
      end
      RSEL_CTRL: begin
        bus_rdata[HALT_BIT]    = halt_w;
        bus_rdata[INHIBIT_BIT] = inhibit_w;
      end
      RSEL_INIT:   bus_rdata = init_word_w;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk #(
  parameter int CNT_W    = 10,
  parameter int INIT_MIN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             reboot_lock_i,
  input logic             sys_rst_o,
  input logic             halt_w,
  input logic             inhibit_w,
  input logic             reload_stb,
  input logic [CNT_W-1:0] count_w,
  input logic [CNT_W-1:0] init_field_w,
  input logic             first_w,
  input logic             second_w
);
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_w && !reload_stb |=> $stable(count_w)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !halt_w && !reload_stb && (count_w > CNT_W'(1))
    |=> count_w == $past(count_w) - CNT_W'(1)); // R2

  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload_stb |=> count_w == $past(init_field_w)); // R3

  AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    init_field_w >= CNT_W'(INIT_MIN)); // R4

  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(second_w) |-> $past(first_w)); // R7

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o); // R10

  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_w |=> !sys_rst_o); // R9

  AST_LOCK_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_lock_i |=> inhibit_w); // R9
endmodule

bind tick_watchdog tick_watchdog_chk #(
  .CNT_W   (CNT_W),
  .INIT_MIN(INIT_MIN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tick_i       (tick_i),
  .reboot_lock_i(reboot_lock_i),
  .sys_rst_o    (sys_rst_o),
  .halt_w       (halt_w),
  .inhibit_w    (inhibit_w),
  .reload_stb   (reload_stb),
  .count_w      (count_w),
  .init_field_w (init_field_w),
  .first_w      (first_w),
  .second_w     (second_w)
);

// File: tb/tb_tick_watchdog.sv
`timescale 1ns/1ps
module tb_tick_watchdog;
  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_TK = 2'd2;
  localparam int NVEC = 36;

  // {op[47:46], addr[45:38], data[37:22], be[21:20], expect[19:4], req[3:0]}
  localparam logic [47:0] VEC [NVEC] = '{
    {OP_RD, 8'h08, 16'h0000, 2'b00, 16'h0801, 4'd1},  // R1 ctrl reset
    {OP_RD, 8'h12, 16'h0000, 2'b00, 16'h0004, 4'd1},  // R1 init reset
    {OP_RD, 8'h00, 16'h0000, 2'b00, 16'h0000, 4'd1},  // R1 count reset
    {OP_RD, 8'h04, 16'h0000, 2'b00, 16'h0000, 4'd1},  // R1
    {OP_RD, 8'h06, 16'h0000, 2'b00, 16'h0000, 4'd1},  // R1
    {OP_WR, 8'h12, 16'h0002, 2'b11, 16'h0000, 4'd4},  // R4 value 2 rejected
    {OP_RD, 8'h12, 16'h0000, 2'b00, 16'h0004, 4'd4},
    {OP_WR, 8'h12, 16'hA806, 2'b11, 16'h0000, 4'd4},  // R4 accepted + upper
    {OP_RD, 8'h12, 16'h0000, 2'b00, 16'hA806, 4'd4},
    {OP_WR, 8'h12, 16'hFC03, 2'b11, 16'h0000, 4'd4},  // R4 field 3 kept, upper stored
    {OP_RD, 8'h12, 16'h0000, 2'b00, 16'hFC06, 4'd4},
    {OP_WR, 8'h00, 16'h1234, 2'b11, 16'h0000, 4'd3},  // R3 reload
    {OP_RD, 8'h00, 16'h0000, 2'b00, 16'h0006, 4'd3},
    {OP_TK, 8'h00, 16'h0000, 2'b00, 16'h0000, 4'd2},  // R2 halted tick
    {OP_RD, 8'h00, 16'h0000, 2'b00, 16'h0006, 4'd2},
    {OP_WR, 8'h08, 16'h0000, 2'b11, 16'h0000, 4'd2},  // R2 release halt
    {OP_RD, 8'h08, 16'h0000, 2'b00, 16'h0000, 4'd2},
    {OP_TK, 8'h00, 16'h0000, 2'b00, 16'h0000, 4'd2},
    {OP_RD, 8'h00, 16'h0000, 2'b00, 16'h0005, 4'd2},  // R2 decrement
    {OP_TK, 8'h00, 16'h0000, 2'b00, 16'h0000, 4'd6},
    {OP_TK, 8'h00, 16'h0000, 2'b00, 16'h0000, 4'd6},
    {OP_TK, 8'h00, 16'h0000, 2'b00, 16'h0000, 4'd6},
    {OP_TK, 8'h00, 16'h0000, 2'b00, 16'h0000, 4'd6},
    {OP_RD, 8'h00, 16'h0000, 2'b00, 16'h0001, 4'd6},  // R6 count at 1
    {OP_RD, 8'h04, 16'h0000, 2'b00, 16'h0000, 4'd6},
    {OP_TK, 8'h00, 16'h0000, 2'b00, 16'h0000, 4'd6},  // R6 expiry
    {OP_RD, 8'h00, 16'h0000, 2'b00, 16'h0006, 4'd6},
    {OP_RD, 8'h04, 16'h0000, 2'b00, 16'h0008, 4'd6},
    {OP_TK, 8'h00, 16'h0000, 2'b00, 16'h0000, 4'd3},
    {OP_WR, 8'h00, 16'h0000, 2'b10, 16'h0000, 4'd3},  // R3 reload via upper lane
    {OP_RD, 8'h00, 16'h0000, 2'b00, 16'h0006, 4'd3},
    {OP_RD, 8'h04, 16'h0000, 2'b00, 16'h0008, 4'd3},  // R3 status kept
    {OP_WR, 8'h08, 16'h0800, 2'b01, 16'h0000, 4'd5},  // R5 halt lane disabled
    {OP_RD, 8'h08, 16'h0000, 2'b00, 16'h0000, 4'd5},
    {OP_WR, 8'h12, 16'h0000, 2'b10, 16'h0000, 4'd5},  // R5 upper lane only
    {OP_RD, 8'h12, 16'h0000, 2'b00, 16'h0006, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        reboot_lock_i;
  logic        sys_rst_o;

  int checks = 0;
  int fails  = 0;
  int rst_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_watchdog dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_be       (bus_be),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .reboot_lock_i(reboot_lock_i),
    .sys_rst_o    (sys_rst_o)
  );

  always @(negedge clk) if (sys_rst_o) rst_cnt++;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                       input logic [1:0] b, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_addr  = a[4:0];
    bus_wdata = d;
    bus_be    = b;
    bus_wr    = (op == OP_WR);
    tick_i    = (op == OP_TK);
    if (op == OP_RD) begin
      #1;
      check(bus_rdata, exp, tag);
    end
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) apply(OP_TK, 8'h00, 16'h0, 2'b00, 16'h0, "tick");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_be = '0; bus_wdata = '0; reboot_lock_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [47:0] e;
      e = VEC[v];
      apply(e[47:46], e[45:38], e[37:22], e[21:20], e[19:4],
            $sformatf("R%0d vector %0d", e[3:0], v));
    end

    // R7 R10: second timeout with inhibit clear -> one reset pulse
    ticks(6);
    repeat (2) @(negedge clk);
    check(16'(rst_cnt), 16'd1, "R10 single reset pulse");
    apply(OP_RD, 8'h06, 16'h0, 2'b00, 16'h0003, "R7 second timeout and issued");
    apply(OP_RD, 8'h00, 16'h0, 2'b00, 16'h0006, "R6 reload after second expiry");

    // R8: write-one-to-clear
    apply(OP_WR, 8'h04, 16'h0000, 2'b11, 16'h0, "w");
    apply(OP_RD, 8'h04, 16'h0, 2'b00, 16'h0008, "R8 zero write keeps flag");
    apply(OP_WR, 8'h06, 16'h0002, 2'b11, 16'h0, "w");
    apply(OP_RD, 8'h06, 16'h0, 2'b00, 16'h0001, "R8 clear second only");
    apply(OP_WR, 8'h06, 16'h0001, 2'b11, 16'h0, "w");
    apply(OP_RD, 8'h06, 16'h0, 2'b00, 16'h0000, "R8 clear issued");
    apply(OP_WR, 8'h04, 16'h0008, 2'b11, 16'h0, "w");
    apply(OP_RD, 8'h04, 16'h0, 2'b00, 16'h0000, "R8 clear first");

    // R9 R10: inhibit set by software blocks the pulse
    apply(OP_WR, 8'h08, 16'h0001, 2'b11, 16'h0, "w");
    ticks(12);
    repeat (2) @(negedge clk);
    check(16'(rst_cnt), 16'd1, "R10 no pulse while inhibited");
    apply(OP_RD, 8'h06, 16'h0, 2'b00, 16'h0002, "R7 second timeout without issue");

    // R9: lock strap holds inhibit at 1
    apply(OP_WR, 8'h06, 16'h0003, 2'b11, 16'h0, "w");
    apply(OP_WR, 8'h04, 16'h0008, 2'b11, 16'h0, "w");
    @(negedge clk);
    reboot_lock_i = 1'b1;
    apply(OP_WR, 8'h08, 16'h0000, 2'b11, 16'h0, "w");
    apply(OP_RD, 8'h08, 16'h0, 2'b00, 16'h0001, "R9 locked inhibit reads 1");
    ticks(12);
    repeat (2) @(negedge clk);
    check(16'(rst_cnt), 16'd1, "R9 no pulse while locked");
    apply(OP_RD, 8'h06, 16'h0, 2'b00, 16'h0002, "R9 second timeout recorded");
    @(negedge clk);
    reboot_lock_i = 1'b0;
    apply(OP_WR, 8'h08, 16'h0000, 2'b11, 16'h0, "w");
    apply(OP_RD, 8'h08, 16'h0, 2'b00, 16'h0000, "R9 unlocked inhibit clears");

    // R1: reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(OP_RD, 8'h08, 16'h0, 2'b00, 16'h0801, "R1 ctrl after reset");
    apply(OP_RD, 8'h00, 16'h0, 2'b00, 16'h0000, "R1 count after reset");
    apply(OP_RD, 8'h12, 16'h0, 2'b00, 16'h0004, "R1 init after reset");
    apply(OP_RD, 8'h06, 16'h0, 2'b00, 16'h0000, "R1 status after reset");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule